// File: doc/BRIEF.md
# Boot Region Remap Decoder

This block decodes the addresses issued by two classes of interconnect masters, processor and non-processor, and picks one target for each request: boot ROM, on-chip RAM, SDRAM, or one of two bridge windows. Along with the target it returns the offset within that target, or a decode error when the address reaches nothing visible. The memories and bridges sit outside the block; it only drives a one-hot target select, the offset and the error flag, one cycle after the request.

A 4-bit remap control register, which can be written but never read back, decides what appears in the lowest 1 MiB ("the zero alias") for each master class and whether each bridge window may be reached. Every write replaces all four bits at once, so software must keep its own copy of the setting. Both small memories are 64 KB, so only the bottom 64 KB of the zero alias maps onto them. The boot ROM and on-chip RAM also keep fixed homes near the top of the 4 GiB space. SDRAM fills the space up to 3 GiB, and the upper 1 GiB belongs to the interconnect.

Top module: `boot_remap_decoder`

## Requirements
- R1: After reset the remap register holds 0000: a processor request in the zero alias goes to the boot ROM, a non-processor request there goes to SDRAM, both bridge windows are hidden, and rsp_valid is 0.
- R2: A request presented with req_valid in one cycle answers with rsp_valid one cycle later. A cycle without a request gives rsp_valid 0, an all-zero target and no error. Target bits are: bit 0 boot ROM, bit 1 on-chip RAM, bit 2 SDRAM, bit 3 bridge A, bit 4 bridge B; exactly one is set on a routed response.
- R3: For processor requests below 0x0010_0000, remap bit 0 selects the boot ROM (0) or the on-chip RAM (1), with offset equal to the address.
- R4: A zero-alias request that lands on the boot ROM or the on-chip RAM at an address of 0x1_0000 or above gives a decode error with an all-zero target and offset.
- R5: For non-processor requests below 0x0010_0000, remap bit 1 selects SDRAM (0, offset equal to the address) or the on-chip RAM (1).
- R6: The boot ROM at 0xFFFD_0000 is reachable by processor requests whatever the remap setting, and gives a decode error for non-processor requests; the on-chip RAM at 0xFFFF_0000 is reachable by both classes. Each window is 64 KB and the offset is the address minus the window base.
- R7: Remap bit 2 makes bridge A (0xC000_0000, 512 MiB) visible and bit 3 does the same for bridge B (0xFF20_0000, 2 MiB); a request to a hidden window gives a decode error, a visible one routes with offset equal to the address minus the window base.
- R8: Requests of either class from 0x0010_0000 up to 0xBFFF_FFFF go to SDRAM with offset equal to the address.
- R9: A request at or above 0xC000_0000 that falls in no window gives a decode error.
- R10: A write replaces all four remap bits at once and affects requests presented from the next cycle on; a request in the same cycle as the write still uses the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for the remap register |
| cfg_wr_data | input | 4 | New remap setting: bit0 processor alias on-chip RAM, bit1 non-processor alias on-chip RAM, bit2 bridge A visible, bit3 bridge B visible |
| req_valid | input | 1 | Request present |
| req_is_cpu | input | 1 | 1 for a processor master, 0 otherwise |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Registered response present |
| rsp_target | output | 5 | One-hot target select |
| rsp_offset | output | 32 | Offset within the selected target |
| rsp_decerr | output | 1 | Decode error |

## Verification
The assertions assume that req_valid and cfg_wr_en are low while reset is held, and that reset lasts several cycles so the remap register is settled before any check on it. They also assume the window parameters do not overlap, so any hit on the boot ROM, on-chip RAM or a bridge comes from one window only. The bench keeps to this by holding every input at zero during a five-cycle reset, driving inputs only on falling edges, and using the default window map. It also covers the same-cycle case of R10 by driving a register write and a request on the same falling edge.

// File: rtl/remap_pkg.sv
package remap_pkg;
  // Target select bit positions (one-hot response vector)
  localparam int T_ROM   = 0;
  localparam int T_OCRAM = 1;
  localparam int T_SDRAM = 2;
  localparam int T_BRA   = 3;
  localparam int T_BRB   = 4;
  localparam int NTGT    = 5;

  // Fixed window indices
  localparam int W_ROM   = 0;
  localparam int W_OCRAM = 1;
  localparam int W_BRA   = 2;
  localparam int W_BRB   = 3;
  localparam int NWIN    = 4;

  // Remap control word; bit 0 is cpu_zero_ocram
  typedef struct packed {
    logic brb_vis;
    logic bra_vis;
    logic dev_zero_ocram;
    logic cpu_zero_ocram;
  } remap_cfg_t;

  localparam int CFG_W = $bits(remap_cfg_t);
endpackage

// File: rtl/remap_cfg_reg.sv
module remap_cfg_reg
  import remap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output remap_cfg_t       cfg
);
  // Write-only: whole word replaced, no read path exists.
  always_ff @(posedge clk) begin
    if (rst)        cfg <= '0;
    else if (wr_en) cfg <= remap_cfg_t'(wr_data);
  end

  // R10: setting changes only on a write
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> $stable(cfg));
endmodule

// File: rtl/remap_window.sv
module remap_window #(
  parameter int              ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [ADDR_W-1:0] SIZE = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  always_comb begin
    offset = addr - BASE;
    hit    = (addr >= BASE) && (offset < SIZE);
  end
endmodule

// File: rtl/remap_route.sv
module remap_route
  import remap_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] MEM_SIZE   = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] ALIAS_SIZE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] UPPER_BASE = 32'hC000_0000
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic                         is_cpu,
  input  remap_cfg_t                   cfg,
  input  logic [NWIN-1:0]              win_hit,
  input  logic [NWIN-1:0][ADDR_W-1:0]  win_off,
  output logic [NTGT-1:0]              target,
  output logic [ADDR_W-1:0]            offset,
  output logic                         decerr
);
  logic in_alias, in_upper, alias_ocram;

  always_comb begin
    target      = '0;
    offset      = '0;
    decerr      = 1'b0;
    in_alias    = addr < ALIAS_SIZE;
    in_upper    = addr >= UPPER_BASE;
    alias_ocram = is_cpu ? cfg.cpu_zero_ocram : cfg.dev_zero_ocram;

    if (in_alias) begin
      if (!is_cpu && !cfg.dev_zero_ocram) begin
        target[T_SDRAM] = 1'b1;
        offset          = addr;
      end else if (addr < MEM_SIZE) begin
        target[alias_ocram ? T_OCRAM : T_ROM] = 1'b1;
        offset = addr;
      end else begin
        decerr = 1'b1;
      end
    end else if (!in_upper) begin
      target[T_SDRAM] = 1'b1;
      offset          = addr;
    end else if (win_hit[W_ROM]) begin
      if (is_cpu) begin
        target[T_ROM] = 1'b1;
        offset        = win_off[W_ROM];
      end else begin
        decerr = 1'b1;
      end
    end else if (win_hit[W_OCRAM]) begin
      target[T_OCRAM] = 1'b1;
      offset          = win_off[W_OCRAM];
    end else if (win_hit[W_BRA]) begin
      if (cfg.bra_vis) begin
        target[T_BRA] = 1'b1;
        offset        = win_off[W_BRA];
      end else begin
        decerr = 1'b1;
      end
    end else if (win_hit[W_BRB]) begin
      if (cfg.brb_vis) begin
        target[T_BRB] = 1'b1;
        offset        = win_off[W_BRB];
      end else begin
        decerr = 1'b1;
      end
    end else begin
      decerr = 1'b1;
    end
  end
endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import remap_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] MEM_SIZE   = 32'h0001_0000,
  parameter logic [ADDR_W-1:0] ALIAS_SIZE = 32'h0010_0000,
  parameter logic [ADDR_W-1:0] UPPER_BASE = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] ROM_BASE   = 32'hFFFD_0000,
  parameter logic [ADDR_W-1:0] OCRAM_BASE = 32'hFFFF_0000,
  parameter logic [ADDR_W-1:0] BRA_BASE   = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] BRA_SIZE   = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] BRB_BASE   = 32'hFF20_0000,
  parameter logic [ADDR_W-1:0] BRB_SIZE   = 32'h0020_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr_en,
  input  logic [3:0]        cfg_wr_data,
  input  logic              req_valid,
  input  logic              req_is_cpu,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [4:0]        rsp_target,
  output logic [ADDR_W-1:0] rsp_offset,
  output logic              rsp_decerr
);
  localparam logic [ADDR_W-1:0] WIN_BASE [NWIN] = '{ROM_BASE, OCRAM_BASE, BRA_BASE, BRB_BASE};
  localparam logic [ADDR_W-1:0] WIN_SIZE [NWIN] = '{MEM_SIZE, MEM_SIZE, BRA_SIZE, BRB_SIZE};

  remap_cfg_t                  cfg;
  logic [NWIN-1:0]             win_hit;
  logic [NWIN-1:0][ADDR_W-1:0] win_off;
  logic [NTGT-1:0]             nxt_target;
  logic [ADDR_W-1:0]           nxt_offset;
  logic                        nxt_decerr;

  remap_cfg_reg u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg     (cfg)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    remap_window #(
      .ADDR_W (ADDR_W),
      .BASE   (WIN_BASE[g]),
      .SIZE   (WIN_SIZE[g])
    ) u_win (
      .addr   (req_addr),
      .hit    (win_hit[g]),
      .offset (win_off[g])
    );
  end

  remap_route #(
    .ADDR_W     (ADDR_W),
    .MEM_SIZE   (MEM_SIZE),
    .ALIAS_SIZE (ALIAS_SIZE),
    .UPPER_BASE (UPPER_BASE)
  ) u_route (
    .addr    (req_addr),
    .is_cpu  (req_is_cpu),
    .cfg     (cfg),
    .win_hit (win_hit),
    .win_off (win_off),
    .target  (nxt_target),
    .offset  (nxt_offset),
    .decerr  (nxt_decerr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_target <= '0;
      rsp_offset <= '0;
      rsp_decerr <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_target <= req_valid ? nxt_target : '0;
      rsp_offset <= req_valid ? nxt_offset : '0;
      rsp_decerr <= req_valid & nxt_decerr;
    end
  end

  // R2: a response only follows a request
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid));
  // R2: routed responses select exactly one target
  assert_target_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_decerr) |-> ($countones(rsp_target) == 1));
  // R4: an error never carries a target
  assert_err_no_target_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_decerr |-> (rsp_valid && rsp_target == '0 && rsp_offset == '0));
  // R4: memory offsets stay inside the 64 KB memory
  assert_mem_offset_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_target[T_ROM] || rsp_target[T_OCRAM])) |-> (rsp_offset < MEM_SIZE));
  // R6: boot ROM is only ever given to processor requests
  assert_rom_cpu_only_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_target[T_ROM]) |-> $past(req_is_cpu));
  // R7: a bridge is routed only while visible
  assert_bra_visible_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_target[T_BRA]) |-> $past(cfg.bra_vis));
  assert_brb_visible_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_target[T_BRB]) |-> $past(cfg.brb_vis));
endmodule

// File: tb/boot_remap_decoder_tb.sv
module boot_remap_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] TROM = 5'b00001, TOCR = 5'b00010, TSDR = 5'b00100,
                         TBRA = 5'b01000, TBRB = 5'b10000, TNONE = 5'b00000;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr_en = 1'b0;
  logic [3:0] cfg_wr_data = '0;
  logic req_valid = 1'b0, req_is_cpu = 1'b0;
  logic [31:0] req_addr = '0;
  logic rsp_valid, rsp_decerr;
  logic [4:0] rsp_target;
  logic [31:0] rsp_offset;
  int n_checks = 0, n_fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_remap_decoder u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .req_valid(req_valid), .req_is_cpu(req_is_cpu), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_target(rsp_target), .rsp_offset(rsp_offset),
    .rsp_decerr(rsp_decerr)
  );

  task automatic check(input string tag, input logic ev, input logic [4:0] et,
                       input logic [31:0] eo, input logic ee);
    n_checks++;
    if (rsp_valid !== ev || rsp_target !== et || rsp_offset !== eo || rsp_decerr !== ee) begin
      n_fails++;
      $display("FAIL %s: got v=%b t=%b o=%h e=%b, expected v=%b t=%b o=%h e=%b",
               tag, rsp_valid, rsp_target, rsp_offset, rsp_decerr, ev, et, eo, ee);
    end
  endtask

  task automatic write_cfg(input logic [3:0] val);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = val;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  // One request; outputs sampled at the next falling edge after capture
  task automatic req(input string tag, input logic cpu, input logic [31:0] a,
                     input logic [4:0] et, input logic [31:0] eo, input logic ee);
    @(negedge clk); req_valid = 1'b1; req_is_cpu = cpu; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
    check(tag, 1'b1, et, eo, ee);
  endtask

  task automatic t_reset;
    check("R1 idle after reset", 1'b0, TNONE, 32'h0, 1'b0);
    req("R1 R3 cpu zero alias boot ROM", 1, 32'h0000_0100, TROM, 32'h100, 0);
    req("R1 R5 dev zero alias SDRAM", 0, 32'h0000_0100, TSDR, 32'h100, 0);
    req("R1 R7 bridge A hidden", 1, 32'hC000_0010, TNONE, 32'h0, 1);
    req("R1 R7 bridge B hidden", 0, 32'hFF20_0010, TNONE, 32'h0, 1);
  endtask

  task automatic t_cpu_alias;
    write_cfg(4'b0001);
    req("R3 cpu alias on-chip RAM", 1, 32'h0000_1234, TOCR, 32'h1234, 0);
    req("R3 cpu alias last byte", 1, 32'h0000_FFFF, TOCR, 32'hFFFF, 0);
    req("R4 cpu alias above 64KB", 1, 32'h0001_0000, TNONE, 32'h0, 1);
    req("R4 cpu alias top of 1MiB", 1, 32'h000F_FFFF, TNONE, 32'h0, 1);
    req("R6 cpu fixed boot ROM", 1, 32'hFFFD_0004, TROM, 32'h4, 0);
    req("R6 cpu fixed on-chip RAM", 1, 32'hFFFF_0008, TOCR, 32'h8, 0);
    req("R5 dev alias still SDRAM", 0, 32'h0001_0000, TSDR, 32'h1_0000, 0);
  endtask

  task automatic t_dev_alias;
    write_cfg(4'b0010);
    req("R5 dev alias on-chip RAM", 0, 32'h0000_0020, TOCR, 32'h20, 0);
    req("R4 dev alias above 64KB", 0, 32'h0008_0000, TNONE, 32'h0, 1);
    req("R10 cpu bit overwritten by write", 1, 32'h0000_0020, TROM, 32'h20, 0);
    req("R6 dev boot ROM window error", 0, 32'hFFFD_0000, TNONE, 32'h0, 1);
    req("R6 dev fixed on-chip RAM", 0, 32'hFFFF_0100, TOCR, 32'h100, 0);
  endtask

  task automatic t_sdram_upper;
    req("R8 cpu SDRAM at 1MiB", 1, 32'h0010_0000, TSDR, 32'h0010_0000, 0);
    req("R8 dev SDRAM top", 0, 32'hBFFF_FFFF, TSDR, 32'hBFFF_FFFF, 0);
    req("R9 upper unmatched", 1, 32'hF000_0000, TNONE, 32'h0, 1);
    req("R9 gap below boot ROM", 1, 32'hFFFC_FFFF, TNONE, 32'h0, 1);
  endtask

  task automatic t_bridges;
    write_cfg(4'b1100);
    req("R7 bridge A visible", 1, 32'hC000_0040, TBRA, 32'h40, 0);
    req("R7 bridge A last byte", 0, 32'hDFFF_FFFF, TBRA, 32'h1FFF_FFFF, 0);
    req("R7 bridge B visible", 0, 32'hFF20_0010, TBRB, 32'h10, 0);
    req("R9 past bridge A", 1, 32'hE000_0000, TNONE, 32'h0, 1);
    write_cfg(4'b0100);
    req("R7 bridge B hidden again", 1, 32'hFF20_0010, TNONE, 32'h0, 1);
    req("R7 bridge A stays visible", 1, 32'hC000_0000, TBRA, 32'h0, 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    check("R2 no request no response", 1'b0, TNONE, 32'h0, 1'b0);
    // Write and request on the same edge: old setting (bridge A visible) applies
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 4'b0000;
    req_valid = 1'b1; req_is_cpu = 1'b1; req_addr = 32'hC000_0080;
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    check("R10 same-cycle write uses old setting", 1'b1, TBRA, 32'h80, 1'b0);
    req("R10 next request uses new setting", 1, 32'hC000_0080, TNONE, 32'h0, 1);
    // Back-to-back requests
    @(negedge clk); req_valid = 1'b1; req_is_cpu = 1'b0; req_addr = 32'h0020_0000;
    @(negedge clk); req_addr = 32'hFFFF_0001; req_is_cpu = 1'b1;
    check("R2 back-to-back first", 1'b1, TSDR, 32'h0020_0000, 1'b0);
    @(negedge clk); req_valid = 1'b0;
    check("R2 back-to-back second", 1'b1, TOCR, 32'h1, 1'b0);
    @(negedge clk);
    check("R2 idle after burst", 1'b0, TNONE, 32'h0, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cpu_alias();
    t_dev_alias();
    t_sdram_upper();
    t_bridges();
    t_timing();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule